// File: doc/BRIEF.md
# Processor bus glue and decoder

This block is the address decode and bus steering logic for an 8-bit processor bus on an instrument controller board. From a 16-bit address, active-low read and write strobes, the bus-valid phase, a forced-instruction jumper and a serial-loop strobe, it drives active-low chip selects for the RAM, the interface adapter, the keyboard/display controller, the GPIB controller and the patch EPROM. It also drives the direction and enable pins of the bidirectional data buffer and a sticky flag that allows shifting into a serial loop.

Most selects come straight from the address bits, so they change as soon as the address settles. The GPIB controller needs the address to be stable before its select arrives. Its select therefore also needs a term qualified by the bus-valid phase, and that term is registered on the clock. The shift-enable flag is set by a write into its address window and cleared by the loop strobe. Shift clocks reach the loop only between a write and the following strobe, which keeps shift-clock noise out of the loop for the rest of the time.

Top module: `glue_decoder`

## Requirements
- R1: With addr_i[15:13]=000, addr_i[12:11] selects one slot, and only that slot's select is low: 00 drives ram_sel_no, 01 drives adapter_sel_no, 10 drives kbd_sel_no and 11 is the GPIB slot. Each slot covers 2 KB, and addr_i[10] does not affect the select, so the 1 KB RAM is mirrored. No select is low for any other address.
- R2: ram_sel_no, adapter_sel_no and kbd_sel_no are combinational from addr_i alone. bus_en_i, rd_ni, wr_ni and loop_strobe_i have no effect on them.
- R3: gpib_sel_no is low only while addr_i is in 1800–1FFF and, at the previous rising clock edge, bus_en_i was high and addr_i was in 1800–1FFF. It therefore asserts one clock after the bus-valid phase starts with a matching address.
- R4: gpib_sel_no goes high again at once, with no clock edge, when addr_i leaves 1800–1FFF.
- R5: patch_sel_no is low when addr_i is in 9800–9FFF (addr_i[15:11]=10011) or when patch_alt_ni is low. Otherwise it is high.
- R6: buf_dir_o is 1 (peripheral side to processor) when rd_ni is low, and 0 (processor side to peripheral) when rd_ni is high.
- R7: buf_en_no is low only when all of these hold: fi_normal_i=1, bus_en_i=1, addr_i[10]=1 and addr_i[15:13]=000. This is the upper 1 KB of each 2 KB block in 0000–1FFF.
- R8: A low wr_ni with addr_i in 8000–87FF (addr_i[15:11]=10000) sets shift_en_o at the next rising clock edge.
- R9: loop_strobe_i high clears shift_en_o at the next rising clock edge. The clear wins when a set arrives in the same cycle.
- R10: While rst_ni is low, shift_en_o is 0 and gpib_sel_no is high, whatever the other inputs are.
- R11: With no set and no strobe, shift_en_o holds its value. This covers reads in 8000–87FF and writes outside that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Processor address |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| bus_en_i | input | 1 | Bus-valid phase, active high |
| fi_normal_i | input | 1 | Forced-instruction jumper, 1 = normal |
| loop_strobe_i | input | 1 | Serial-loop strobe, clears the shift flag |
| patch_alt_ni | input | 1 | Alternate patch EPROM select from programmable logic, active low |
| ram_sel_no | output | 1 | RAM select, active low |
| adapter_sel_no | output | 1 | Interface adapter select, active low |
| kbd_sel_no | output | 1 | Keyboard/display select, active low |
| gpib_sel_no | output | 1 | GPIB controller select, active low |
| patch_sel_no | output | 1 | Patch EPROM select, active low |
| buf_dir_o | output | 1 | Buffer direction, 1 = toward processor |
| buf_en_no | output | 1 | Buffer enable, active low |
| shift_en_o | output | 1 | Serial-loop shift enable flag |

## Verification
The random address generator favours the four low slots, the patch window and the shift window, and also draws fully random addresses. This separates slot decoding from aliasing and out-of-range rejection. Strobes, bus phase, jumper and loop strobe are randomised on their own, and the address is held for several cycles at random. This shows which selects ignore the bus phase and tells the registered GPIB qualification apart from the combinational drop when the address changes. Directed sequences cover the first cycle of a GPIB access, a set and a clear in the same cycle, reads inside the shift window, and outputs held during reset.

// File: rtl/glue_pkg.sv
package glue_pkg;
  typedef enum logic [1:0] {
    SLOT_RAM  = 2'd0,
    SLOT_ADP  = 2'd1,
    SLOT_KBD  = 2'd2,
    SLOT_GPIB = 2'd3
  } slot_e;

  localparam int NUM_SLOTS = 4;
  localparam int SLOT_W    = 2;
  localparam int WIN_W     = 3;   // upper bits that pick the low window
  localparam int PFX_W     = 5;   // upper bits that pick a 2 KB window
  localparam logic [PFX_W-1:0] PATCH_PFX = 5'b10011;
  localparam logic [PFX_W-1:0] SHIFT_PFX = 5'b10000;
endpackage

// File: rtl/glue_addr_dec.sv
module glue_addr_dec
  import glue_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BLK_LSB = 11
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_SLOTS-1:0] slot_hit_o,
  output logic                 low_win_o,
  output logic                 patch_hit_o,
  output logic                 shift_win_o
);
  localparam int TOP = ADDR_W - 1;

  logic [PFX_W-1:0] pfx;
  assign pfx         = addr_i[TOP -: PFX_W];
  assign low_win_o   = (addr_i[TOP -: WIN_W] == '0);
  assign patch_hit_o = (pfx == PATCH_PFX);
  assign shift_win_o = (pfx == SHIFT_PFX);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign slot_hit_o[s] = low_win_o &&
                           (addr_i[BLK_LSB +: SLOT_W] == SLOT_W'(s));
  end
endmodule

// File: rtl/glue_gpib_qual.sv
module glue_gpib_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_en_i,
  input  logic hit_i,
  output logic sel_no
);
  logic qual_q;

  // enable-qualified term, one clock behind the phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) qual_q <= 1'b0;
    else         qual_q <= bus_en_i & hit_i;
  end

  // OR of two active-low terms
  assign sel_no = ~hit_i | ~qual_q;
endmodule

// File: rtl/glue_shift_flag.sv
module glue_shift_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (clr_i) flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
  end
endmodule

// File: rtl/glue_decoder.sv
module glue_decoder
  import glue_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BLK_LSB = 11,
  parameter int BUF_BIT = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic              bus_en_i,
  input  logic              fi_normal_i,
  input  logic              loop_strobe_i,
  input  logic              patch_alt_ni,
  output logic              ram_sel_no,
  output logic              adapter_sel_no,
  output logic              kbd_sel_no,
  output logic              gpib_sel_no,
  output logic              patch_sel_no,
  output logic              buf_dir_o,
  output logic              buf_en_no,
  output logic              shift_en_o
);
  logic [NUM_SLOTS-1:0] slot_hit;
  logic low_win, patch_hit, shift_win;

  glue_addr_dec #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB)) u_dec (
    .addr_i      (addr_i),
    .slot_hit_o  (slot_hit),
    .low_win_o   (low_win),
    .patch_hit_o (patch_hit),
    .shift_win_o (shift_win)
  );

  assign ram_sel_no     = ~slot_hit[SLOT_RAM];
  assign adapter_sel_no = ~slot_hit[SLOT_ADP];
  assign kbd_sel_no     = ~slot_hit[SLOT_KBD];
  assign patch_sel_no   = ~patch_hit & patch_alt_ni;

  glue_gpib_qual u_gpib (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bus_en_i (bus_en_i),
    .hit_i    (slot_hit[SLOT_GPIB]),
    .sel_no   (gpib_sel_no)
  );

  assign buf_dir_o = ~rd_ni;
  // enable-qualified low-range select, upper half of each block, normal jumper
  assign buf_en_no = ~(fi_normal_i & addr_i[BUF_BIT] & bus_en_i & low_win);

  glue_shift_flag u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (~wr_ni & shift_win),
    .clr_i  (loop_strobe_i),
    .flag_o (shift_en_o)
  );
endmodule

// File: rtl/glue_checker.sv
module glue_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_ni,
  input logic              wr_ni,
  input logic              bus_en_i,
  input logic              fi_normal_i,
  input logic              loop_strobe_i,
  input logic              patch_alt_ni,
  input logic              ram_sel_no,
  input logic              adapter_sel_no,
  input logic              kbd_sel_no,
  input logic              gpib_sel_no,
  input logic              patch_sel_no,
  input logic              buf_dir_o,
  input logic              buf_en_no,
  input logic              shift_en_o
);
  localparam int TOP = ADDR_W - 1;
  logic in_shift_win;
  assign in_shift_win = (addr_i[TOP -: 5] == 5'b10000);

  AST_SEL_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({~ram_sel_no, ~adapter_sel_no, ~kbd_sel_no, ~gpib_sel_no})); // R1
  AST_GPIB_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gpib_sel_no |-> $past(bus_en_i)); // R3
  AST_GPIB_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gpib_sel_no |-> (addr_i[TOP -: 5] == 5'b00011)); // R4
  AST_PATCH_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[TOP -: 5] == 5'b10011) |-> !patch_sel_no); // R5
  AST_BUF_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !buf_en_no |-> (addr_i[10] && fi_normal_i && bus_en_i)); // R7
  AST_SHIFT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ni && in_shift_win && !loop_strobe_i) |=> shift_en_o); // R8
  AST_SHIFT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_strobe_i |=> !shift_en_o); // R9
  AST_SHIFT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!loop_strobe_i && !(!wr_ni && in_shift_win)) |=> $stable(shift_en_o)); // R11
endmodule

bind glue_decoder glue_checker #(.ADDR_W(ADDR_W)) u_glue_checker (.*);

// File: tb/tb_glue_decoder.sv
module tb_glue_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        rd_n = 1'b1, wr_n = 1'b1, bus_en = 1'b0, fi_n = 1'b1;
  logic        strobe = 1'b0, alt_n = 1'b1;
  logic        ram_n, adp_n, kbd_n, gpib_n, patch_n, dir, buf_n, shift;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  glue_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_ni(rd_n), .wr_ni(wr_n),
    .bus_en_i(bus_en), .fi_normal_i(fi_n), .loop_strobe_i(strobe),
    .patch_alt_ni(alt_n), .ram_sel_no(ram_n), .adapter_sel_no(adp_n),
    .kbd_sel_no(kbd_n), .gpib_sel_no(gpib_n), .patch_sel_no(patch_n),
    .buf_dir_o(dir), .buf_en_no(buf_n), .shift_en_o(shift)
  );

  // reference state, built from the requirements
  logic m_qual, m_shift;
  function automatic bit in_slot(logic [15:0] a, int s);
    return (a[15:13] == 3'b000) && (a[12:11] == s[1:0]);
  endfunction
  function automatic bit in_pfx(logic [15:0] a, logic [4:0] p);
    return a[15:11] == p;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_qual  <= 1'b0;
      m_shift <= 1'b0;
    end else begin
      m_qual <= bus_en && in_slot(addr, 3);
      if (strobe)                                  m_shift <= 1'b0;
      else if (!wr_n && in_pfx(addr, 5'b10000))    m_shift <= 1'b1;
    end
  end

  task automatic chk(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h got=%b exp=%b t=%0t", tag, addr, got, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(ram_n,   !in_slot(addr, 0), "R1/R2 ram select");
    chk(adp_n,   !in_slot(addr, 1), "R1/R2 adapter select");
    chk(kbd_n,   !in_slot(addr, 2), "R1/R2 kbd select");
    chk(gpib_n,  !(in_slot(addr, 3) && m_qual), "R3/R4 gpib select");
    chk(patch_n, !(in_pfx(addr, 5'b10011) || !alt_n), "R5 patch select");
    chk(dir,     !rd_n, "R6 buffer direction");
    chk(buf_n,   !(fi_n && bus_en && addr[10] && addr[15:13] == 3'b000), "R7 buffer enable");
    chk(shift,   m_shift, "R8/R9/R11 shift flag");
  endtask

  task automatic drive(input logic [15:0] a, input logic r, input logic w,
                       input logic be, input logic st);
    @(negedge clk);
    addr = a; rd_n = r; wr_n = w; bus_en = be; strobe = st;
    #1 check_all();
  endtask

  function automatic logic [15:0] pick_addr();
    logic [15:0] a = 16'($urandom);
    case ($urandom % 8)
      0, 1, 2, 3: a[15:11] = {3'b000, 2'($urandom)};
      4:          a[15:11] = 5'b10011;
      5:          a[15:11] = 5'b10000;
      default:    ;
    endcase
    return a;
  endfunction

  initial begin
    void'($urandom(32'h5eed_0c0b));
    // R10: outputs held in reset despite active inputs
    addr = 16'h1c00; bus_en = 1'b1; wr_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(shift, 1'b0, "R10 shift in reset");
    chk(gpib_n, 1'b1, "R10 gpib in reset");
    addr = 16'h8010; wr_n = 1'b0;
    @(posedge clk); #1;
    chk(shift, 1'b0, "R10 write ignored in reset");
    @(negedge clk);
    rst_n = 1'b1; wr_n = 1'b1; bus_en = 1'b0;

    // R3: first cycle of a GPIB access not selected, next one selected
    drive(16'h1a00, 1, 1, 1, 0);
    chk(gpib_n, 1'b1, "R3 gpib first cycle");
    drive(16'h1a00, 0, 1, 1, 0);
    chk(gpib_n, 1'b0, "R3 gpib second cycle");
    // R4: address leaves window, deselect without an edge
    @(negedge clk); #0.5 addr = 16'h1000; #0.5;
    chk(gpib_n, 1'b1, "R4 gpib immediate drop");
    // phase low: no qualification
    drive(16'h1b00, 1, 1, 0, 0);
    drive(16'h1b00, 1, 1, 0, 0);
    chk(gpib_n, 1'b1, "R3 gpib without phase");

    // R9: set and clear in the same cycle, clear wins
    drive(16'h8123, 1, 0, 1, 1);
    drive(16'h0000, 1, 1, 1, 0);
    chk(shift, 1'b0, "R9 clear beats set");
    // R8: set
    drive(16'h87ff, 1, 0, 1, 0);
    drive(16'h0000, 1, 1, 1, 0);
    chk(shift, 1'b1, "R8 write sets flag");
    // R11: read in window, write outside window, hold
    drive(16'h8400, 0, 1, 1, 0);
    drive(16'h8800, 1, 0, 1, 0);
    drive(16'h0000, 1, 1, 1, 0);
    chk(shift, 1'b1, "R11 flag held");
    drive(16'h0000, 1, 1, 1, 1);
    drive(16'h0000, 1, 1, 1, 0);
    chk(shift, 1'b0, "R9 strobe clears");

    // R1/R2/R5/R7 corners
    drive(16'h03ff, 1, 1, 1, 0);
    chk(ram_n, 1'b0, "R1 ram lower mirror");
    chk(buf_n, 1'b1, "R7 lower half blocked");
    drive(16'h0400, 1, 1, 1, 0);
    chk(buf_n, 1'b0, "R7 upper half open");
    fi_n = 1'b0; #0.5;
    chk(buf_n, 1'b1, "R7 forced jumper blocks");
    fi_n = 1'b1;
    drive(16'h2400, 1, 1, 1, 0);
    chk(buf_n, 1'b1, "R7 outside low range");
    chk(ram_n, 1'b1, "R1 no select above 1FFF");
    drive(16'h9fff, 1, 1, 0, 0);
    chk(patch_n, 1'b0, "R5 patch window top");
    drive(16'ha000, 1, 1, 0, 0);
    chk(patch_n, 1'b1, "R5 above patch window");
    alt_n = 1'b0; #0.5;
    chk(patch_n, 1'b0, "R5 alternate select");
    alt_n = 1'b1;

    // random phase
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ($urandom % 2) addr = pick_addr();
      rd_n   = 1'($urandom);
      wr_n   = ($urandom % 3) != 0;
      bus_en = ($urandom % 4) != 0;
      fi_n   = ($urandom % 6) != 0;
      strobe = ($urandom % 8) == 0;
      alt_n  = ($urandom % 8) != 0;
      #1 check_all();
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule